// File: doc/BRIEF.md
# Address Window Match Unit

This block fuses two address limit registers into a single window detector for an on-chip debug unit. On every valid bus cycle it compares the address against a lower limit (comparator A) and an upper limit (comparator B). It then reports a hit either when the address falls inside the closed window or when it falls outside it, depending on the selected mode. Only comparator A's settings can further narrow the hit: its masked data pattern, with an optional match-on-difference sense, and its direction filter.

The result appears one clock after the qualifying bus cycle as a registered pulse. Alongside it come a tag request and a break request, each gated by comparator A's tag and break bits. Comparator B's direction, tag and break bits are accepted at the ports but never influence the result. The same holds for comparator A's access-size settings and the bus access-size signal.

Top module: `addr_window_cmp`

## Requirements
- R1: A hit is possible only when both `a_en` and `b_en` are 1. With either or both at 0, `hit_o`, `tag_req_o` and `brk_req_o` stay 0.
- R2: With `mode_outside`=0 (inside mode), a hit needs `a_lim` <= address and address <= `b_lim` in the same bus cycle. Both limits are inclusive, and satisfying only one of them gives no hit.
- R3: With `mode_outside`=1 (outside mode), a hit occurs when the address is below `a_lim` or above `b_lim`. Either condition alone is enough.
- R4: A word access is judged only by the even address on `bus_addr`, even if its second byte lies past a limit. A word at address `b_lim` (even) hits in inside mode and does not hit in outside mode.
- R5: When `a_dir_en`=1, a hit also requires `bus_rd` (1 = read) to equal `a_dir_rd`. When `a_dir_en`=0, direction is not checked. `b_dir_en` and `b_dir_rd` have no effect.
- R6: `a_size_en`, `a_size` and `bus_word` have no effect on any output.
- R7: Data bit i of `bus_data` is compared with bit i of `a_data` only where `a_dmask[i]`=1. With `a_dinv`=0, every compared bit must be equal. With `a_dinv`=1, every compared bit must differ.
- R8: When `a_tag`=1, address bit 0 is dropped from both limit compares, so limits resolve to whole words.
- R9: `tag_req_o` equals `hit_o` AND the value of `a_tag` in the qualifying cycle. `brk_req_o` equals `hit_o` AND `a_brk` in that cycle. `b_tag` and `b_brk` have no effect.
- R10: All outputs are registered. They are high exactly in the cycle after a qualifying bus cycle and are 0 while `rst_n` is 0.
- R11: A cycle with `bus_valid`=0 never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 18 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | Access size (ignored) |
| mode_outside | input | 1 | 0 = inside window, 1 = outside window |
| a_en | input | 1 | Comparator A enable |
| a_lim | input | 18 | Lower window limit |
| a_data | input | 16 | Data reference pattern |
| a_dmask | input | 16 | Per-bit data compare enable |
| a_dinv | input | 1 | Data match on difference |
| a_dir_en | input | 1 | Direction filter enable |
| a_dir_rd | input | 1 | Required direction (1 = read) |
| a_size_en | input | 1 | Size filter enable (ignored) |
| a_size | input | 1 | Size select (ignored) |
| a_tag | input | 1 | Tag mode, word-granular limits |
| a_brk | input | 1 | Break request enable |
| b_en | input | 1 | Comparator B enable |
| b_lim | input | 18 | Upper window limit |
| b_dir_en | input | 1 | Direction enable of B (ignored) |
| b_dir_rd | input | 1 | Direction select of B (ignored) |
| b_tag | input | 1 | Tag bit of B (ignored) |
| b_brk | input | 1 | Break bit of B (ignored) |
| hit_o | output | 1 | Registered window hit pulse |
| tag_req_o | output | 1 | Registered tag request |
| brk_req_o | output | 1 | Registered break request |

## Verification
The hardest case to reach is a window hit that depends on several qualifiers at once: an address sitting exactly on a limit, word granularity dropping bit 0, and a data pattern matching only under the difference sense. A single change in the wrong stage still yields plausible pulses. The vector table therefore pins each qualifier separately against addresses placed one unit either side of each limit, and against the odd address just past an even upper limit. Every row drives comparator B's ignored bits and the size bits to values that would change the result if they leaked in.

// File: rtl/awc_pkg.sv
package awc_pkg;
   typedef enum logic {
      WIN_INSIDE  = 1'b0,
      WIN_OUTSIDE = 1'b1
   } win_mode_e;

   typedef struct packed {
      logic below;
      logic above;
   } lim_rel_t;
endpackage

// File: rtl/awc_limit_cmp.sv
module awc_limit_cmp
   import awc_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] limit,
   input  logic              word_gran,
   output lim_rel_t          rel
);
   localparam int HI = ADDR_W - 1;

   logic [HI:0] a_eff;
   logic [HI:0] l_eff;

   // word granularity drops the byte-select bit on both sides
   assign a_eff = {addr[HI:1],  addr[0]  & ~word_gran};
   assign l_eff = {limit[HI:1], limit[0] & ~word_gran};

   always_comb begin
      rel.below = (a_eff < l_eff);
      rel.above = (a_eff > l_eff);
   end
endmodule

// File: rtl/awc_data_qual.sv
module awc_data_qual #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] ref_pat,
   input  logic [DATA_W-1:0] mask,
   input  logic              inv,
   output logic              ok
);
   logic [DATA_W-1:0] bit_ok;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      // masked-off bit always passes; otherwise equality or difference per inv
      assign bit_ok[i] = ~mask[i] | ~(data[i] ^ ref_pat[i] ^ inv);
   end

   assign ok = &bit_ok;
endmodule

// File: rtl/awc_hit_reg.sv
module awc_hit_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_d,
   input  logic tag_d,
   input  logic brk_d,
   output logic hit_q,
   output logic tag_q,
   output logic brk_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         tag_q <= 1'b0;
         brk_q <= 1'b0;
      end else begin
         hit_q <= hit_d;
         tag_q <= hit_d & tag_d;
         brk_q <= hit_d & brk_d;
      end
   end
endmodule

// File: rtl/addr_window_cmp.sv
module addr_window_cmp
   import awc_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rd,
   input  logic              bus_word,
   input  logic              mode_outside,
   input  logic              a_en,
   input  logic [ADDR_W-1:0] a_lim,
   input  logic [DATA_W-1:0] a_data,
   input  logic [DATA_W-1:0] a_dmask,
   input  logic              a_dinv,
   input  logic              a_dir_en,
   input  logic              a_dir_rd,
   input  logic              a_size_en,
   input  logic              a_size,
   input  logic              a_tag,
   input  logic              a_brk,
   input  logic              b_en,
   input  logic [ADDR_W-1:0] b_lim,
   input  logic              b_dir_en,
   input  logic              b_dir_rd,
   input  logic              b_tag,
   input  logic              b_brk,
   output logic              hit_o,
   output logic              tag_req_o,
   output logic              brk_req_o
);
   localparam int N_CMP = 2;

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("addr_window_cmp: ADDR_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("addr_window_cmp: DATA_W must be at least 1");
   end

   logic [ADDR_W-1:0] lim_pair [N_CMP];
   lim_rel_t          rel_pair [N_CMP];

   assign lim_pair[0] = a_lim;
   assign lim_pair[1] = b_lim;

   for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
      awc_limit_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .addr      (bus_addr),
         .limit     (lim_pair[c]),
         .word_gran (a_tag),
         .rel       (rel_pair[c])
      );
   end

   logic data_ok;
   awc_data_qual #(.DATA_W(DATA_W)) u_dq (
      .data    (bus_data),
      .ref_pat (a_data),
      .mask    (a_dmask),
      .inv     (a_dinv),
      .ok      (data_ok)
   );

   win_mode_e mode;
   logic      armed;
   logic      in_win;
   logic      win_ok;
   logic      dir_ok;
   logic      hit_d;

   assign mode   = win_mode_e'(mode_outside);
   assign armed  = a_en & b_en & bus_valid;
   assign in_win = ~rel_pair[0].below & ~rel_pair[1].above;
   assign dir_ok = ~a_dir_en | (bus_rd == a_dir_rd);

   always_comb begin
      unique case (mode)
         WIN_INSIDE:  win_ok = in_win;
         WIN_OUTSIDE: win_ok = rel_pair[0].below | rel_pair[1].above;
         default:     win_ok = 1'b0;
      endcase
   end

   assign hit_d = armed & win_ok & dir_ok & data_ok;

   awc_hit_reg u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_d (hit_d),
      .tag_d (a_tag),
      .brk_d (a_brk),
      .hit_q (hit_o),
      .tag_q (tag_req_o),
      .brk_q (brk_req_o)
   );

   // settings that range matching deliberately disregards
   logic unused_cfg;
   assign unused_cfg = ^{bus_word, a_size_en, a_size, b_dir_en, b_dir_rd, b_tag, b_brk};
endmodule

// File: rtl/awc_checker.sv
module awc_checker #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              mode_outside,
   input logic              a_en,
   input logic              b_en,
   input logic [ADDR_W-1:0] a_lim,
   input logic [ADDR_W-1:0] b_lim,
   input logic              a_tag,
   input logic              a_dir_en,
   input logic              a_dir_rd,
   input logic [DATA_W-1:0] a_dmask,
   input logic              hit_o,
   input logic              tag_req_o,
   input logic              brk_req_o
);
   logic plain;
   assign plain = bus_valid && a_en && b_en && !a_tag && !a_dir_en && (a_dmask == '0);

   assert_need_both_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en && b_en) |=> !hit_o);

   assert_inside_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && !mode_outside && bus_addr >= a_lim && bus_addr <= b_lim) |=> hit_o);

   assert_inside_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !mode_outside && !a_tag && (bus_addr < a_lim || bus_addr > b_lim)) |=> !hit_o);

   assert_outside_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && mode_outside && (bus_addr < a_lim || bus_addr > b_lim)) |=> hit_o);

   assert_dir_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && a_dir_en && bus_rd != a_dir_rd) |=> !hit_o);

   assert_tag_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req_o |-> hit_o);

   assert_brk_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req_o |-> hit_o);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !hit_o);
endmodule

bind addr_window_cmp awc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_awc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_valid    (bus_valid),
   .bus_addr     (bus_addr),
   .bus_rd       (bus_rd),
   .mode_outside (mode_outside),
   .a_en         (a_en),
   .b_en         (b_en),
   .a_lim        (a_lim),
   .b_lim        (b_lim),
   .a_tag        (a_tag),
   .a_dir_en     (a_dir_en),
   .a_dir_rd     (a_dir_rd),
   .a_dmask      (a_dmask),
   .hit_o        (hit_o),
   .tag_req_o    (tag_req_o),
   .brk_req_o    (brk_req_o)
);

// File: tb/addr_window_cmp_tb_top.sv
`timescale 1ns/100ps
module addr_window_cmp_tb_top;
   localparam int AW = 18;
   localparam int DW = 16;
   localparam logic [DW-1:0] REF = 16'hA5C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          bus_valid, bus_rd, bus_word, mode_outside;
   logic [AW-1:0] bus_addr, a_lim, b_lim;
   logic [DW-1:0] bus_data, a_data, a_dmask;
   logic          a_en, a_dinv, a_dir_en, a_dir_rd, a_size_en, a_size, a_tag, a_brk;
   logic          b_en, b_dir_en, b_dir_rd, b_tag, b_brk;
   logic          hit_o, tag_req_o, brk_req_o;

   addr_window_cmp dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word),
      .mode_outside(mode_outside), .a_en(a_en), .a_lim(a_lim), .a_data(a_data),
      .a_dmask(a_dmask), .a_dinv(a_dinv), .a_dir_en(a_dir_en), .a_dir_rd(a_dir_rd),
      .a_size_en(a_size_en), .a_size(a_size), .a_tag(a_tag), .a_brk(a_brk),
      .b_en(b_en), .b_lim(b_lim), .b_dir_en(b_dir_en), .b_dir_rd(b_dir_rd),
      .b_tag(b_tag), .b_brk(b_brk), .hit_o(hit_o), .tag_req_o(tag_req_o),
      .brk_req_o(brk_req_o)
   );

   typedef struct packed {
      logic          outside;
      logic [AW-1:0] addr;
      logic          rd;
      logic          tag;
      logic          dir_en;
      logic          dir_rd;
      logic [DW-1:0] mask;
      logic          inv;
      logic [DW-1:0] data;
      logic          exp_hit;
   } vec_t;

   localparam int NV = 17;
   // limits fixed at a_lim=0x100, b_lim=0x1FE
   localparam vec_t VECS [NV] = '{
      '{1'b0, 18'h100, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R2 lower inclusive
      '{1'b0, 18'h0FF, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R2 below
      '{1'b0, 18'h1FE, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R4 word at upper limit
      '{1'b0, 18'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R2 above
      '{1'b1, 18'h0FF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R3 below
      '{1'b1, 18'h200, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R3 above
      '{1'b1, 18'h150, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R3 inside window
      '{1'b1, 18'h1FE, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R4 straddle outside
      '{1'b0, 18'h150, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R5 wrong dir
      '{1'b0, 18'h150, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R5 right dir
      '{1'b0, 18'h150, 1'b1, 1'b0, 1'b0, 1'b0, 16'h00FF, 1'b0, 16'h12C3, 1'b1}, // R7 equal
      '{1'b0, 18'h150, 1'b1, 1'b0, 1'b0, 1'b0, 16'h00FF, 1'b0, 16'h12C2, 1'b0}, // R7 unequal
      '{1'b0, 18'h150, 1'b1, 1'b0, 1'b0, 1'b0, 16'h000F, 1'b1, 16'h000C, 1'b1}, // R7 differ
      '{1'b0, 18'h150, 1'b1, 1'b0, 1'b0, 1'b0, 16'h000F, 1'b1, 16'h0003, 1'b0}, // R7 not differ
      '{1'b0, 18'h1FF, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R8 inside word
      '{1'b1, 18'h1FF, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8 outside word
      '{1'b0, 18'h0FF, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}  // R8 below word
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic idle_cfg();
      bus_valid = 1'b0; bus_addr = '0; bus_data = '0; bus_rd = 1'b0; bus_word = 1'b0;
      mode_outside = 1'b0; a_en = 1'b1; b_en = 1'b1; a_lim = 18'h100; b_lim = 18'h1FE;
      a_data = REF; a_dmask = '0; a_dinv = 1'b0; a_dir_en = 1'b0; a_dir_rd = 1'b0;
      a_size_en = 1'b0; a_size = 1'b0; a_tag = 1'b0; a_brk = 1'b0;
      b_dir_en = 1'b0; b_dir_rd = 1'b0; b_tag = 1'b0; b_brk = 1'b0;
   endtask

   // one bus cycle at a plain inside address, result checked one clock later
   task automatic one_cycle(input string req, input logic exp);
      @(negedge clk);
      bus_valid = 1'b1; bus_addr = 18'h150;
      @(negedge clk);
      bus_valid = 1'b0;
      chk(req, hit_o, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle_cfg();
      bus_valid = 1'b1; bus_addr = 18'h150;
      repeat (3) @(negedge clk);
      // R10: outputs held low in reset even with a qualifying cycle present
      chk("R10 reset hit", hit_o, 1'b0);
      chk("R10 reset tag", tag_req_o, 1'b0);
      chk("R10 reset brk", brk_req_o, 1'b0);
      bus_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         mode_outside = VECS[i].outside; bus_addr = VECS[i].addr; bus_rd = VECS[i].rd;
         a_tag = VECS[i].tag; a_dir_en = VECS[i].dir_en; a_dir_rd = VECS[i].dir_rd;
         a_dmask = VECS[i].mask; a_dinv = VECS[i].inv; bus_data = VECS[i].data;
         a_brk = 1'b1; b_tag = 1'b1; b_brk = 1'b1;
         // R6 and R5/R9 ignored settings: all set against the row's expectation
         a_size_en = 1'b1; a_size = i[0]; bus_word = ~i[0];
         b_dir_en = 1'b1; b_dir_rd = ~VECS[i].rd;
         bus_valid = 1'b1;
         @(negedge clk);
         bus_valid = 1'b0;
         chk($sformatf("R2/R3/R4/R5/R6/R7/R8 row %0d hit", i), hit_o, VECS[i].exp_hit);
         chk($sformatf("R9 row %0d tag", i), tag_req_o, VECS[i].exp_hit & VECS[i].tag);
         chk($sformatf("R9 row %0d brk", i), brk_req_o, VECS[i].exp_hit);
         @(negedge clk);
         chk($sformatf("R10 row %0d pulse ends", i), hit_o, 1'b0);
      end

      idle_cfg();
      a_en = 1'b1; b_en = 1'b0;
      one_cycle("R1 only A enabled", 1'b0);
      a_en = 1'b0; b_en = 1'b1;
      one_cycle("R1 only B enabled", 1'b0);
      a_en = 1'b0; b_en = 1'b0;
      one_cycle("R1 both disabled", 1'b0);
      a_en = 1'b1; b_en = 1'b1;
      one_cycle("R1 both enabled", 1'b1);

      // R11: address in window but no valid cycle
      @(negedge clk);
      bus_addr = 18'h150; bus_valid = 1'b0;
      @(negedge clk);
      chk("R11 idle cycle", hit_o, 1'b0);

      // R10: back-to-back cycles give back-to-back pulses, then stop
      @(negedge clk);
      bus_valid = 1'b1; bus_addr = 18'h150;
      @(negedge clk);
      chk("R10 first of pair", hit_o, 1'b1);
      bus_addr = 18'h050;
      @(negedge clk);
      chk("R10 second misses", hit_o, 1'b0);
      bus_addr = 18'h160;
      @(negedge clk);
      bus_valid = 1'b0;
      chk("R10 third hits", hit_o, 1'b1);
      @(negedge clk);
      chk("R10 returns low", hit_o, 1'b0);

      // R9: tag and break follow A's bits of the qualifying cycle only
      a_tag = 1'b0; a_brk = 1'b0; b_tag = 1'b1; b_brk = 1'b1;
      @(negedge clk);
      bus_valid = 1'b1; bus_addr = 18'h150;
      @(negedge clk);
      bus_valid = 1'b0;
      chk("R9 B tag ignored", tag_req_o, 1'b0);
      chk("R9 B brk ignored", brk_req_o, 1'b0);

      // R10: reset clears a pulse in flight
      @(negedge clk);
      bus_valid = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R10 async reset clears", hit_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule